// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost-Flag Offset

This block is a 64-entry, 36-bit first-in first-out store that joins two clock domains which may be fully unrelated. Words are pushed on the rising edge of the write clock and popped on the rising edge of the read clock. Each side qualifies its transfers with an active-low select and an active-high enable. The write side reports a full flag and an almost-full flag, and the read side reports an empty flag and an almost-empty flag. All four flags are active low.

A single threshold X sets both almost flags. X comes from one of four presets, chosen by a two-bit select that is captured when reset is released. Pointers cross between the domains in Gray code through two-stage synchronizers. That is why a flag clears two edges of the receiving clock after the event that clears it.

The write side holds a small start-up sequencer with three states. In HOLD (the reset state) the FIFO reports full. The first write-clock edge after reset moves HOLD to ARM (the "wake" transition). The second edge moves ARM to RUN (the "arm" transition). RUN is final until the next reset, and writes are possible only there. Read data leaves through an output register that loads only on an accepted read.

Top module: `async_pflag_fifo`

## Requirements
- R1: A write is accepted on a rising `wclk` edge only when `wr_cs_n`=0, `wr_en`=1 and `full_n`=1. A read is accepted on a rising `rclk` edge only when `rd_cs_n`=0, `rd_en`=1 and `empty_n`=1. Any other cycle moves no data.
- R2: While `rst_n` is low, `full_n`=0, `empty_n`=0 and `rd_data`=0.
- R3: After `rst_n` rises, `full_n` is still 0 after the first rising `wclk` edge and is 1 after the second.
- R4: After a word is written into an empty FIFO, `empty_n` is still 0 after the first following rising `rclk` edge and is 1 after the second.
- R5: While `full_n`=0, a write attempt stores nothing and overwrites nothing.
- R6: While `empty_n`=0, a read attempt leaves `rd_data` and the stored words unchanged.
- R7: Words are read out in the order in which they were written, bit-exact over all 36 bits.
- R8: Once the pointers have settled, `aempty_n` is 0 exactly when the stored word count is less than or equal to X.
- R9: Once the pointers have settled, `afull_n` is 0 exactly when the number of free locations (64 minus the count) is less than or equal to X.
- R10: X is loaded on the rising edge of `rst_n` from `off_sel`: 00 gives 16, 01 gives 12, 10 gives 8, 11 gives 4. Changes to `off_sel` at any other time have no effect.
- R11: `rd_data` changes only on a rising `rclk` edge that accepts a read, and then shows the oldest stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low; its rising edge captures `off_sel` |
| off_sel | input | 2 | Preset select for the almost-flag threshold |
| wr_cs_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write-side enable, active high |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when full or still starting up (write domain) |
| afull_n | output | 1 | Low when free locations <= X (write domain) |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read-side enable, active high |
| rd_data | output | 36 | Output register holding the last word read |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when stored count <= X (read domain) |

## Verification
The bench sweeps all four threshold codes. For each code it fills the FIFO one word at a time to 64, then drains it, and checks both almost flags against the arithmetic threshold at every fill level. A design with an off-by-one compare would flip a flag one level early or late, and one that samples `off_sel` at the wrong moment would use the wrong threshold, because the bench scrambles `off_sel` after reset.

Flag latency is checked edge by edge after reset release and after the first word. A design missing a synchronizer stage, or with an extra one, is caught there. Writes at full, reads at empty and half-qualified select/enable combinations are followed by a full in-order readout. A design that let any of them through would show a corrupted or shifted word, or a changed output register.

// File: rtl/fifo_flag_pkg.sv
`timescale 1ns/10ps
package fifo_flag_pkg;

    typedef enum logic [1:0] {
        WS_HOLD = 2'd0,
        WS_ARM  = 2'd1,
        WS_RUN  = 2'd2
    } wstart_e;

    function automatic int unsigned preset_offset(input logic [1:0] sel);
        unique case (sel)
            2'b00: return 16;
            2'b01: return 12;
            2'b10: return 8;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/gray_xing.sv
`timescale 1ns/10ps
module gray_xing #(
    parameter int W = 7
) (
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    assign bin_out[W-1] = stage2_q[W-1];
    for (genvar i = W - 2; i >= 0; i--) begin : g_dec
        assign bin_out[i] = bin_out[i+1] ^ stage2_q[i];
    end

    p_sync_step_r4: assert property (@(posedge dst_clk) disable iff (!rst_n)
        $countones(stage2_q ^ $past(stage2_q)) <= 1)
        else $error("synchronized pointer jumped more than one Gray step");

endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/10ps
module fifo_ram #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/10ps
module fifo_wr_side
    import fifo_flag_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          en,
    input  logic [AW:0]   rbin_sync,
    input  logic [AW:0]   offset,
    output logic          wr_go,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

    wstart_e     state_q, state_d;
    logic [AW:0] wbin_q;
    logic [AW:0] wbin_nx;
    logic [AW:0] used;
    logic        at_top;

    // start-up sequencer: state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_HOLD;
        else        state_q <= state_d;
    end

    // start-up sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_HOLD: state_d = WS_ARM;   // wake
            WS_ARM:  state_d = WS_RUN;   // arm
            WS_RUN:  state_d = WS_RUN;
            default: state_d = WS_HOLD;
        endcase
    end

    // flag outputs
    always_comb begin
        used    = wbin_q - rbin_sync;
        at_top  = (used == DEPTH);
        full_n  = (state_q == WS_RUN) && !at_top;
        afull_n = (DEPTH - used) > offset;
    end

    assign wr_go   = !cs_n && en && full_n;
    assign wbin_nx = wbin_q + 1'b1;
    assign waddr   = wbin_q[AW-1:0];

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q <= '0;
            wgray  <= '0;
        end else if (wr_go) begin
            wbin_q <= wbin_nx;
            wgray  <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wbin_q))
        else $error("write pointer moved while full");

    p_fill_bound_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        used <= DEPTH)
        else $error("fill level exceeds depth");

    p_full_in_afull_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        (state_q == WS_RUN && !full_n) |-> !afull_n)
        else $error("full without almost-full");

    p_gray_step_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1)
        else $error("write Gray pointer changed more than one bit");

    p_startup_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        $rose(full_n) |-> $past(state_q) != WS_HOLD)
        else $error("full flag released before second edge");

endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/10ps
module fifo_rd_side #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          en,
    input  logic [AW:0]   wbin_sync,
    input  logic [AW:0]   offset,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic          aempty_n,
    output logic [DW-1:0] rd_data
);
    logic [AW:0] rbin_q;
    logic [AW:0] rbin_nx;
    logic [AW:0] held;
    logic        rd_go;

    always_comb begin
        held     = wbin_sync - rbin_q;
        empty_n  = (held != '0);
        aempty_n = held > offset;
    end

    assign rd_go   = !cs_n && en && empty_n;
    assign rbin_nx = rbin_q + 1'b1;
    assign raddr   = rbin_q[AW-1:0];

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else if (rd_go) begin
            rbin_q  <= rbin_nx;
            rgray   <= rbin_nx ^ (rbin_nx >> 1);
            rd_data <= mem_q;
        end
    end

    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rbin_q))
        else $error("read pointer moved while empty");

    p_data_hold_r11: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data))
        else $error("output register changed without a read");

    p_empty_in_aempty_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n)
        else $error("empty without almost-empty");

endmodule

// File: rtl/async_pflag_fifo.sv
`timescale 1ns/10ps
module async_pflag_fifo
    import fifo_flag_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        off_sel,
    input  logic              wr_cs_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_cs_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     offset_q;
    logic              wr_go;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray;
    logic [PW-1:0]     wbin_in_r, rbin_in_w;
    logic [DATA_W-1:0] mem_q;

    // threshold captured once, on the release of reset
    always_ff @(posedge rst_n) begin
        offset_q <= PW'(preset_offset(off_sel));
    end

    fifo_wr_side #(.AW(ADDR_W)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .cs_n      (wr_cs_n),
        .en        (wr_en),
        .rbin_sync (rbin_in_w),
        .offset    (offset_q),
        .wr_go     (wr_go),
        .waddr     (waddr),
        .wgray     (wgray),
        .full_n    (full_n),
        .afull_n   (afull_n)
    );

    gray_xing #(.W(PW)) u_r2w (
        .dst_clk (wclk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rbin_in_w)
    );

    gray_xing #(.W(PW)) u_w2r (
        .dst_clk (rclk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wbin_in_r)
    );

    fifo_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .wclk  (wclk),
        .we    (wr_go),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    fifo_rd_side #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .cs_n      (rd_cs_n),
        .en        (rd_en),
        .wbin_sync (wbin_in_r),
        .offset    (offset_q),
        .mem_q     (mem_q),
        .raddr     (raddr),
        .rgray     (rgray),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/async_pflag_fifo_tb.sv
`timescale 1ns/10ps
module async_pflag_fifo_tb;

    logic        wclk, rclk, rst_n;
    logic [1:0]  off_sel;
    logic        wr_cs_n, wr_en, rd_cs_n, rd_en;
    logic [35:0] wr_data, rd_data;
    logic        full_n, afull_n, empty_n, aempty_n;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    async_pflag_fifo u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .off_sel(off_sel),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    initial begin
        wclk = 0;
        forever #2.5 wclk = ~wclk;
    end

    initial begin
        rclk = 1;
        #1.25;
        forever #2.5 rclk = ~rclk;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [35:0] pat(input int s, input int i);
        logic [31:0] m;
        m = 32'(i) * 32'h9E37_79B9;
        return {4'(s + 1), m ^ 32'h5A5A_0000};
    endfunction

    task automatic wr_word(input logic [35:0] d, input logic cs_n, input logic en);
        @(negedge wclk);
        wr_cs_n = cs_n; wr_en = en; wr_data = d;
        @(posedge wclk);
        #1;
        wr_cs_n = 1; wr_en = 0;
    endtask

    task automatic rd_word(input logic cs_n, input logic en);
        @(negedge rclk);
        rd_cs_n = cs_n; rd_en = en;
        @(posedge rclk);
        #1;
        rd_cs_n = 1; rd_en = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge wclk);
    endtask

    task automatic flags(input int cnt, input int x, input string tag);
        check(aempty_n == (cnt > x), {"R8 ", tag}, 64'(aempty_n), 64'(cnt > x));
        check(afull_n == ((64 - cnt) > x), {"R9 ", tag}, 64'(afull_n), 64'((64 - cnt) > x));
        check(empty_n == (cnt > 0), {"R4 ", tag}, 64'(empty_n), 64'(cnt > 0));
        check(full_n == (cnt < 64), {"R5 ", tag}, 64'(full_n), 64'(cnt < 64));
    endtask

    initial begin
        rst_n = 0; off_sel = 0;
        wr_cs_n = 1; wr_en = 0; wr_data = '0;
        rd_cs_n = 1; rd_en = 0;
        for (int s = 0; s < 4; s++) begin
            int x;
            logic [35:0] held;
            x = (s == 0) ? 16 : (s == 1) ? 12 : (s == 2) ? 8 : 4;  // R10 preset table
            @(negedge wclk);
            rst_n = 0;
            off_sel = 2'(s);
            repeat (3) @(negedge wclk);
            check(full_n == 0, "R2 full_n in reset", 64'(full_n), 0);
            check(empty_n == 0, "R2 empty_n in reset", 64'(empty_n), 0);
            check(rd_data == 0, "R2 rd_data in reset", 64'(rd_data), 0);
            @(negedge wclk);
            rst_n = 1;
            @(posedge wclk); #1;
            check(full_n == 0, "R3 full_n after first edge", 64'(full_n), 0);
            @(posedge wclk); #1;
            check(full_n == 1, "R3 full_n after second edge", 64'(full_n), 1);
            off_sel = ~2'(s);  // R10: must be ignored now
            // fill
            for (int n = 1; n <= 64; n++) begin
                if (n == 10) begin
                    wr_word(36'hDEAD_BEEF1, 1'b1, 1'b1);  // R1 deselected
                    wr_word(36'hDEAD_BEEF2, 1'b0, 1'b0);  // R1 not enabled
                end
                wr_word(pat(s, n - 1), 1'b0, 1'b1);
                if (n == 1) begin
                    @(posedge rclk); #1;
                    check(empty_n == 0, "R4 empty_n after first rclk edge", 64'(empty_n), 0);
                    @(posedge rclk); #1;
                    check(empty_n == 1, "R4 empty_n after second rclk edge", 64'(empty_n), 1);
                end
                settle();
                flags(n, x, "fill R10");
            end
            wr_word(36'hBAD_0BAD0, 1'b0, 1'b1);  // R5 write at full
            settle();
            check(full_n == 0, "R5 full_n stays low", 64'(full_n), 0);
            // drain
            for (int n = 1; n <= 64; n++) begin
                rd_word(1'b0, 1'b1);
                check(rd_data == pat(s, n - 1), "R7 R1 order", 64'(rd_data), 64'(pat(s, n - 1)));
                if (n == 20) begin
                    held = rd_data;
                    rd_word(1'b1, 1'b1);
                    check(rd_data == held, "R11 R1 deselected read", 64'(rd_data), 64'(held));
                    rd_word(1'b0, 1'b0);
                    check(rd_data == held, "R11 R1 disabled read", 64'(rd_data), 64'(held));
                end
                settle();
                flags(64 - n, x, "drain R10");
            end
            held = rd_data;
            rd_word(1'b0, 1'b1);  // R6 read at empty
            check(rd_data == held, "R6 rd_data held at empty", 64'(rd_data), 64'(held));
            settle();
            check(empty_n == 0, "R6 empty_n stays low", 64'(empty_n), 0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule